// File: doc/BRIEF.md
# Run-time configurable asynchronous frame receiver

This block recovers asynchronous serial frames from one or more idle-high lines that are sampled once per clock. The frame format is chosen at run time: 5 to 9 data bits, one of four parity modes, whether parity errors are reported, and whether data arrives least- or most-significant bit first. One bit lasts `cfg_div` clocks, so the integrator sets `cfg_div` to the sample rate divided by the baud rate. A frame begins on a high-to-low transition and ends with exactly one stop bit. Every bit is sampled at its centre.

Each lane has its own receiver, with its own state, bit counter and data register. The default build has two lanes, for example one watching each direction of a full-duplex link. The format inputs are shared by all lanes. Each lane copies them when it detects a start edge, so a change during a frame takes effect at the next frame. When the stop bit has been sampled, the lane updates its word, parity bit and error flags and pulses its valid strobe for one clock. Those outputs then hold until the next frame completes.

Top module: `dual_frame_rx`

## Requirements
- R1: `cfg_nbits` selects 5 to 9 data bits. Each lane copies the whole format (`cfg_nbits`, `cfg_parity`, `cfg_par_chk`, `cfg_msb_first`) on the start edge, so a change made during a frame does not affect that frame. Bits of the word at and above the data width read 0.
- R2: One bit lasts `cfg_div` clocks, with `cfg_div` at least 4. The start bit is sampled `cfg_div/2` clocks (rounded down) after the first clock that sees the line low. Each later bit is sampled `cfg_div` clocks after the one before it.
- R3: With `cfg_msb_first`=0, the first data bit on the line lands in bit 0 of the word.
- R4: With `cfg_msb_first`=1, the first data bit on the line lands in bit `cfg_nbits`-1 of the word.
- R5: `cfg_parity` encodes the mode: 0 none, 1 odd, 2 even, 3 mark. The parity bit follows the last data bit. Count the ones in the data word plus the parity bit. Odd mode passes when that total is odd, and even mode passes when it is even. A failing frame sets `par_err_o`. `par_bit_o` gives the received parity bit.
- R6: With parity mode none, there is no parity slot, and the stop bit follows the last data bit directly. In that mode `par_bit_o` and `par_err_o` read 0.
- R7: In mark mode the check passes only when the received parity bit is 1.
- R8: With `cfg_par_chk`=0, `par_err_o` stays 0 whatever parity bit arrives.
- R9: `valid_o` is high for exactly one clock per frame. It rises on the clock edge that samples the centre of the stop bit. It is therefore visible 1 + (nbits+1+P)*div + div/2 clock periods after the start bit is driven, where P is 1 with parity and 0 without.
- R10: A stop bit sampled low sets `frm_err_o` for that frame. A stop bit sampled high clears it.
- R11: A start bit that is high again at its centre is a false start. The lane returns to idle and produces no strobe.
- R12: Lanes are independent. Overlapping frames on different lanes are each received correctly.
- R13: After reset all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Clocks per bit (>= 4) |
| cfg_nbits | input | 4 | Data bits per frame, 5..9 |
| cfg_parity | input | 2 | Parity mode: 0 none, 1 odd, 2 even, 3 mark |
| cfg_par_chk | input | 1 | 1 enables parity error reporting |
| cfg_msb_first | input | 1 | 1 means the most significant data bit is sent first |
| line_i | input | NLANES | Serial lines, idle high, already synchronous to clk |
| word_o | output | NLANES*DATA_W | Received word per lane, lane 0 in the low slice |
| par_bit_o | output | NLANES | Received parity bit per lane |
| par_err_o | output | NLANES | Parity error of the last frame per lane |
| frm_err_o | output | NLANES | Framing error of the last frame per lane |
| valid_o | output | NLANES | One-clock strobe when a lane finishes a frame |

## Verification
The assertions assume two things about the inputs: `cfg_nbits` stays within 5 to 9, and `cfg_div` is never below 4. They also assume that the lines are already synchronous to the clock, because the receiver has no synchroniser of its own. The stimulus sets every format input before a frame starts, with one exception: the latching test changes the format deliberately in the middle of a frame. The bench changes each line only on a falling clock edge, and it holds every bit for exactly `cfg_div` clocks, so the centre sample always falls well inside the bit.

// File: rtl/frame_rx_pkg.sv
// Shared types for the configurable frame receiver.
// Assumes data widths never exceed 9 bits, so a 4-bit width field suffices.
package frame_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_MARK = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        par_mode_e  parity;
        logic       chk;
        logic       msb;
    } frame_cfg_t;

endpackage

// File: rtl/frame_bit_timer.sv
// Bit-centre timer. While run is low it preloads for a new frame.
// While run is high it first pulses mid_o div/2 clocks into the start
// bit, then pulses it every div clocks after that.
// Assumes div >= 4, so that half is never 0.
module frame_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mid_o
);
    logic [DIV_W-1:0] cnt;
    logic             first;
    logic [DIV_W-1:0] half;

    assign half  = div >> 1;
    assign mid_o = run && (first ? (cnt == half) : (cnt == div - DIV_W'(1)));

    // Tick counter: preload while idle, restart at each bit centre.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= DIV_W'(1);
            first <= 1'b1;
        end else if (mid_o) begin
            cnt   <= '0;
            first <= 1'b0;
        end else begin
            cnt   <= cnt + DIV_W'(1);
        end
    end

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !first) |-> (cnt < div));
endmodule

// File: rtl/frame_shifter.sv
// Data assembly register. It clears on request, and on each shift it
// takes one new bit. LSB-first shifts right with the new bit entering
// at position nbits-1. MSB-first shifts left with the new bit entering
// at position 0. Assumes it is cleared before every frame.
module frame_shifter #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_i,
    input  logic              msb,
    input  logic [3:0]        nbits,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] shr;
    logic [DATA_W-1:0] nxt;

    assign shr = word_o >> 1;

    // Next-value selection for both bit orders.
    always_comb begin
        if (msb) begin
            nxt = {word_o[DATA_W-2:0], bit_i};
        end else begin
            for (int j = 0; j < DATA_W; j++) begin
                if (j == int'(nbits) - 1)      nxt[j] = bit_i;
                else if (j < int'(nbits) - 1)  nxt[j] = shr[j];
                else                           nxt[j] = 1'b0;
            end
        end
    end

    // Storage update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) word_o <= '0;
        else if (shift)      word_o <= nxt;
    end
endmodule

// File: rtl/frame_parity_chk.sv
// Parity judgement on a completed frame. It counts the data ones plus
// the parity bit. Assumes the unused upper bits of the word are 0.
module frame_parity_chk
    import frame_rx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              pbit_i,
    input  par_mode_e         mode,
    input  logic              chk,
    output logic              err_o
);
    logic odd_total;

    assign odd_total = (^word_i) ^ pbit_i;

    // Error decode per mode.
    always_comb begin
        unique case (mode)
            PAR_ODD:  err_o = chk && !odd_total;
            PAR_EVEN: err_o = chk && odd_total;
            PAR_MARK: err_o = chk && !pbit_i;
            default:  err_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/frame_rx_lane.sv
// One receiver lane. It finds the start edge, copies the format, samples
// each bit at its centre, and publishes the word, parity bit and error
// flags together with a one-clock strobe at the stop-bit centre.
// Assumes line_i is synchronous to clk, and that the format inputs are
// legal on the clock that sees the start edge.
module frame_rx_lane
    import frame_rx_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_cfg_t        cfg,
    input  logic [DIV_W-1:0]  div,
    input  logic              line_i,
    output logic [DATA_W-1:0] word_o,
    output logic              par_bit_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic              valid_o
);
    rx_state_e         state;
    frame_cfg_t        cfg_q;
    logic              line_q;
    logic [3:0]        bitcnt;
    logic              pbit;
    logic              mid;
    logic              err;
    logic [DATA_W-1:0] word;
    logic              last_data;

    assign last_data = (bitcnt == cfg_q.nbits - 4'd1);

    frame_bit_timer #(.DIV_W(DIV_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .div(div), .mid_o(mid)
    );

    frame_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_START),
        .shift(state == ST_DATA && mid), .bit_i(line_i), .msb(cfg_q.msb),
        .nbits(cfg_q.nbits), .word_o(word)
    );

    frame_parity_chk #(.DATA_W(DATA_W)) i_par (
        .word_i(word), .pbit_i(pbit), .mode(cfg_q.parity), .chk(cfg_q.chk), .err_o(err)
    );

    // Previous line level, used to find the falling start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_i;
    end

    // Frame sequencing: state, format copy, bit count and parity capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cfg_q  <= '0;
            bitcnt <= '0;
            pbit   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (line_q && !line_i) begin
                    state <= ST_START;
                    cfg_q <= cfg;
                end
                ST_START: if (mid) begin
                    state  <= line_i ? ST_IDLE : ST_DATA;
                    bitcnt <= '0;
                    pbit   <= 1'b0;
                end
                ST_DATA: if (mid) begin
                    bitcnt <= bitcnt + 4'd1;
                    if (last_data)
                        state <= (cfg_q.parity == PAR_NONE) ? ST_STOP : ST_PAR;
                end
                ST_PAR: if (mid) begin
                    pbit  <= line_i;
                    state <= ST_STOP;
                end
                ST_STOP: if (mid) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result publication at the stop-bit centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o    <= '0;
            par_bit_o <= 1'b0;
            par_err_o <= 1'b0;
            frm_err_o <= 1'b0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state == ST_STOP && mid) begin
                word_o    <= word;
                par_bit_o <= pbit;
                par_err_o <= err;
                frm_err_o <= !line_i;
                valid_o   <= 1'b1;
            end
        end
    end

    assert_width_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cfg_q.nbits >= 4'd5 && cfg_q.nbits <= 4'd9));
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((word_o >> cfg_q.nbits) == '0));
    assert_div_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(4));
    assert_no_parity_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cfg_q.parity == PAR_NONE) |-> (!par_bit_o && !par_err_o));
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_start_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) == ST_IDLE) |-> ($past(line_q) && !$past(line_i)));
endmodule

// File: rtl/dual_frame_rx.sv
// Multi-lane frame receiver top. It shares one format setting across
// NLANES independent receiver lanes. Assumes lines are pre-synchronised.
module dual_frame_rx
    import frame_rx_pkg::*;
#(
    parameter int NLANES = 2,
    parameter int DATA_W = 9,
    parameter int DIV_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DIV_W-1:0]         cfg_div,
    input  logic [3:0]               cfg_nbits,
    input  logic [1:0]               cfg_parity,
    input  logic                     cfg_par_chk,
    input  logic                     cfg_msb_first,
    input  logic [NLANES-1:0]        line_i,
    output logic [NLANES*DATA_W-1:0] word_o,
    output logic [NLANES-1:0]        par_bit_o,
    output logic [NLANES-1:0]        par_err_o,
    output logic [NLANES-1:0]        frm_err_o,
    output logic [NLANES-1:0]        valid_o
);
    frame_cfg_t cfg;

    assign cfg = '{nbits: cfg_nbits, parity: par_mode_e'(cfg_parity),
                   chk: cfg_par_chk, msb: cfg_msb_first};

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        frame_rx_lane #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_lane (
            .clk(clk), .rst_n(rst_n), .cfg(cfg), .div(cfg_div), .line_i(line_i[g]),
            .word_o(word_o[g*DATA_W +: DATA_W]), .par_bit_o(par_bit_o[g]),
            .par_err_o(par_err_o[g]), .frm_err_o(frm_err_o[g]), .valid_o(valid_o[g])
        );
    end
endmodule

// File: tb/test_dual_frame_rx.sv
module test_dual_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd16;
    logic [3:0]  cfg_nbits = 4'd8;
    logic [1:0]  cfg_parity = 2'd0;
    logic        cfg_par_chk = 1'b1;
    logic        cfg_msb_first = 1'b0;
    logic        line0 = 1'b1, line1 = 1'b1;
    logic [17:0] word_o;
    logic [1:0]  par_bit_o, par_err_o, frm_err_o, valid_o;

    int checks = 0, errors = 0;
    int got_idx[2], got_cnt[2];
    logic [8:0] got_word[2];
    logic got_pb[2], got_pe[2], got_fe[2];

    always #5 clk = ~clk;

    dual_frame_rx i_dual_frame_rx (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nbits(cfg_nbits),
        .cfg_parity(cfg_parity), .cfg_par_chk(cfg_par_chk), .cfg_msb_first(cfg_msb_first),
        .line_i({line1, line0}), .word_o(word_o), .par_bit_o(par_bit_o),
        .par_err_o(par_err_o), .frm_err_o(frm_err_o), .valid_o(valid_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_line(int lane, logic v);
        if (lane == 0) line0 = v; else line1 = v;
    endtask

    function automatic logic good_pbit(logic [8:0] d, int n, int par);
        logic x = ^(d & ((9'h1 << n) - 9'h1));
        case (par)
            1: return ~x;
            2: return x;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int exp_idx(int n, int par, int div);
        return 1 + (n + 1 + (par != 0 ? 1 : 0)) * div + div / 2;
    endfunction

    // Drives one frame starting at the current falling edge.
    task automatic drive_frame(int lane, int n, int par, logic msb, int div,
                               logic [8:0] d, logic pb, logic stopv);
        set_line(lane, 1'b0);
        repeat (div) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            set_line(lane, msb ? d[n-1-i] : d[i]);
            repeat (div) @(negedge clk);
        end
        if (par != 0) begin
            set_line(lane, pb);
            repeat (div) @(negedge clk);
        end
        set_line(lane, stopv);
        repeat (div) @(negedge clk);
        set_line(lane, 1'b1);
        repeat (div) @(negedge clk);
    endtask

    // Watches one lane's strobe, recording the first arrival and the count.
    task automatic watch(int lane, int lim);
        got_idx[lane] = -1;
        got_cnt[lane] = 0;
        for (int idx = 1; idx <= lim; idx++) begin
            @(negedge clk);
            if (valid_o[lane]) begin
                if (got_cnt[lane] == 0) begin
                    got_idx[lane]  = idx;
                    got_word[lane] = word_o[lane*9 +: 9];
                    got_pb[lane]   = par_bit_o[lane];
                    got_pe[lane]   = par_err_o[lane];
                    got_fe[lane]   = frm_err_o[lane];
                end
                got_cnt[lane]++;
            end
        end
    endtask

    task automatic set_cfg(int n, int par, logic chk, logic msb, int div);
        cfg_nbits = 4'(n); cfg_parity = 2'(par); cfg_par_chk = chk;
        cfg_msb_first = msb; cfg_div = 16'(div);
    endtask

    task automatic xfer(int lane, int n, int par, logic msb, int div,
                        logic [8:0] d, logic flip, logic stopv, output logic pb);
        pb = good_pbit(d, n, par) ^ flip;
        fork
            drive_frame(lane, n, par, msb, div, d, pb, stopv);
            watch(lane, (n + 4) * div);
        join
        check("R9 one strobe per frame", got_cnt[lane], 1);
        check("R2 R9 strobe timing", got_idx[lane], exp_idx(n, par, div));
    endtask

    task automatic t_reset();
        check("R13 reset word", int'(word_o), 0);
        check("R13 reset valid", int'(valid_o), 0);
        check("R13 reset flags", int'({par_bit_o, par_err_o, frm_err_o}), 0);
    endtask

    task automatic t_lsb8();
        logic pb;
        set_cfg(8, 0, 1, 0, 16);
        xfer(0, 8, 0, 0, 16, 9'h0A5, 0, 1, pb);
        check("R3 lsb-first word", int'(got_word[0]), 'hA5);
        check("R10 good stop", int'(got_fe[0]), 0);
    endtask

    task automatic t_msb7_odd();
        logic pb;
        set_cfg(7, 1, 1, 1, 10);
        xfer(0, 7, 1, 1, 10, 9'h04B, 0, 1, pb);
        check("R4 msb-first word", int'(got_word[0]), 'h4B);
        check("R5 odd parity bit", int'(got_pb[0]), int'(pb));
        check("R5 odd parity pass", int'(got_pe[0]), 0);
    endtask

    task automatic t_even9_bad();
        logic pb;
        set_cfg(9, 2, 1, 0, 16);
        xfer(1, 9, 2, 0, 16, 9'h1C3, 0, 1, pb);
        check("R1 nine-bit word", int'(got_word[1]), 'h1C3);
        check("R5 even parity pass", int'(got_pe[1]), 0);
        xfer(1, 9, 2, 0, 16, 9'h1C3, 1, 1, pb);
        check("R5 even parity error", int'(got_pe[1]), 1);
        check("R5 wrong parity bit seen", int'(got_pb[1]), int'(pb));
    endtask

    task automatic t_mark();
        logic pb;
        set_cfg(8, 3, 1, 0, 16);
        xfer(0, 8, 3, 0, 16, 9'h033, 0, 1, pb);
        check("R7 mark one passes", int'(got_pe[0]), 0);
        xfer(0, 8, 3, 0, 16, 9'h033, 1, 1, pb);
        check("R7 mark zero fails", int'(got_pe[0]), 1);
    endtask

    task automatic t_chk_off();
        logic pb;
        set_cfg(8, 1, 0, 0, 16);
        xfer(0, 8, 1, 0, 16, 9'h07E, 1, 1, pb);
        check("R8 check disabled", int'(got_pe[0]), 0);
        check("R8 parity bit still reported", int'(got_pb[0]), int'(pb));
    endtask

    task automatic t_none5();
        logic pb;
        set_cfg(5, 0, 1, 0, 8);
        xfer(0, 5, 0, 0, 8, 9'h015, 0, 1, pb);
        check("R6 R1 five-bit word", int'(got_word[0]), 'h15);
        check("R6 no parity bit", int'(got_pb[0]), 0);
        check("R6 no parity error", int'(got_pe[0]), 0);
    endtask

    task automatic t_framing();
        logic pb;
        set_cfg(8, 0, 1, 0, 16);
        xfer(0, 8, 0, 0, 16, 9'h05A, 0, 0, pb);
        check("R10 low stop flagged", int'(got_fe[0]), 1);
        xfer(0, 8, 0, 0, 16, 9'h0C3, 0, 1, pb);
        check("R10 recovery flag clear", int'(got_fe[0]), 0);
        check("R10 recovery word", int'(got_word[0]), 'hC3);
    endtask

    task automatic t_false_start();
        logic pb;
        set_cfg(8, 0, 1, 0, 16);
        fork
            begin
                set_line(0, 1'b0);
                repeat (2) @(negedge clk);
                set_line(0, 1'b1);
            end
            watch(0, 12 * 16);
        join
        check("R11 false start no strobe", got_cnt[0], 0);
        xfer(0, 8, 0, 0, 16, 9'h081, 0, 1, pb);
        check("R11 next frame word", int'(got_word[0]), 'h81);
    endtask

    task automatic t_dual();
        logic pa, pb2;
        set_cfg(8, 2, 1, 0, 16);
        pa  = good_pbit(9'h0F0, 8, 2);
        pb2 = good_pbit(9'h00F, 8, 2);
        fork
            drive_frame(0, 8, 2, 0, 16, 9'h0F0, pa, 1);
            watch(0, 13 * 16);
            begin
                repeat (37) @(negedge clk);
                drive_frame(1, 8, 2, 0, 16, 9'h00F, ~pb2, 1);
            end
            begin
                repeat (37) @(negedge clk);
                watch(1, 13 * 16);
            end
        join
        check("R12 lane0 word", int'(got_word[0]), 'hF0);
        check("R12 lane0 parity ok", int'(got_pe[0]), 0);
        check("R12 lane1 word", int'(got_word[1]), 'h0F);
        check("R12 lane1 parity error", int'(got_pe[1]), 1);
        check("R12 lane1 timing", got_idx[1], exp_idx(8, 2, 16));
    endtask

    task automatic t_cfg_latch();
        set_cfg(8, 0, 1, 0, 16);
        fork
            drive_frame(0, 8, 0, 0, 16, 9'h0B6, 0, 1);
            watch(0, 12 * 16);
            begin
                repeat (3 * 16) @(negedge clk);
                cfg_nbits = 4'd5; cfg_msb_first = 1'b1; cfg_parity = 2'd1;
            end
        join
        check("R1 format copied at start", int'(got_word[0]), 'hB6);
        check("R1 copied timing", got_idx[0], exp_idx(8, 0, 16));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lsb8();
        t_msb7_odd();
        t_even9_bad();
        t_mark();
        t_chk_off();
        t_none5();
        t_framing();
        t_false_start();
        t_dual();
        t_cfg_latch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule